// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Stage

This block is the storage and output stage of one cell in a programmable logic fabric. It takes a sum-of-products term from the logic array, or a bypass bit from a pin, and passes it through a selectable inverter. The result can then be kept in a storage element. That element can act as an edge-triggered D register or as a level-sensitive D latch. Its clock comes from one of four global clocks or from a product-term clock. Its enable, its asynchronous clear and its asynchronous set can each come from a global signal or from a product-term signal.

Two outputs are available at the same time. One always carries the inverter result. The other carries either the stored bit or that same inverter result. The whole behaviour is set by a 14-bit configuration word, written through a simple write strobe and cleared by reset. The cell works in a single system clock domain. The fabric clocks it selects are treated as sampled levels, and a rising edge is seen as a low sample followed by a high one.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst` is high at a `clk` edge, the configuration word clears to zero and the stored bit clears to 0. A zero word means: sum-of-products data, no inversion, register mode, global clock 0, rising edge, enable always active, no clear or set sources, and `reg_out` showing the stored bit.
- R2: `comb_out` equals the selected data bit XOR config bit 1 (invert). It follows input changes with no clock delay.
- R3: Config bit 0 selects the data source: 0 takes `sop_in`, 1 takes `io_in`. The selection applies both to `comb_out` and to the stored data.
- R4: In register mode (config bit 2 = 0), the stored bit takes the `comb_out` value at a `clk` edge where the effective clock is sampled high and was sampled low at the previous edge. The stored bit holds while the clock stays high or low.
- R5: Config bits 5:3 select the clock: codes 0 to 3 pick `gclk[0]` to `gclk[3]`, code 4 picks `pt_clk`, and codes 5 to 7 pick no clock, so the stored bit never changes.
- R6: Config bit 6 inverts the selected clock. In register mode the capture then happens on its falling edge.
- R7: Config bits 8:7 select the enable: 0 always active, 1 `gce`, 2 `pt_ce`, 3 both `gce` and `pt_ce`. No capture happens while the enable is inactive.
- R8: In latch mode (config bit 2 = 1), while the effective clock is high and the enable is active, the stored output follows the data with no clock delay. After the clock goes low it holds the value present at the last `clk` edge.
- R9: Clear is active when (config bit 9 and `g_rst`) or (config bit 10 and `pt_rst`). Set is active when (config bit 11 and `g_set`) or (config bit 12 and `pt_set`). Both act on the stored output at once, without waiting for a clock, and clear wins over set.
- R10: Config bit 13 = 0 makes `reg_out` show the stored bit. Config bit 13 = 1 makes it show the `comb_out` value, while the stored bit is kept.
- R11: When `cfg_we` is high at a `clk` edge, `cfg_wdata` becomes the configuration word. The new word has effect only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration word to store |
| sop_in | input | 1 | Sum-of-products data from the logic array |
| io_in | input | 1 | Bypass data from the pin |
| gclk | input | 4 | Global fabric clocks, sampled as levels |
| pt_clk | input | 1 | Product-term clock, sampled as a level |
| gce | input | 1 | Global clock enable |
| pt_ce | input | 1 | Product-term clock enable |
| g_rst | input | 1 | Global asynchronous clear request |
| pt_rst | input | 1 | Product-term asynchronous clear request |
| g_set | input | 1 | Global asynchronous set request |
| pt_set | input | 1 | Product-term asynchronous set request |
| comb_out | output | 1 | Combinational output (data XOR invert) |
| reg_out | output | 1 | Stored bit, or the combinational value |

## Verification
Some results are due with no clock delay: `comb_out`, the transparent latch path, and the clear or set override. The bench checks these 1 ns after it changes the inputs, before the next `clk` edge. A register capture and a configuration write take effect at the first `clk` edge that sees them. The bench drives inputs 1 ns after a rising edge and reads the result 1 ns after the edge that follows. A clock edge inside the cell needs one low sample and then one high sample, so each pulse task holds the fabric clock for whole system cycles. Every scenario starts from a fresh reset, so its expected values depend only on its own stimulus.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int N_GCLK = 4;
    localparam int CSEL_W = $clog2(N_GCLK + 1);
    localparam logic [CSEL_W-1:0] CSEL_PT = CSEL_W'(N_GCLK);

    typedef enum logic [1:0] {
        CE_ALWAYS = 2'd0,
        CE_GLOBAL = 2'd1,
        CE_PTERM  = 2'd2,
        CE_BOTH   = 2'd3
    } ce_src_e;

    // Field order fixes the bit positions of the configuration word (LSB last).
    typedef struct packed {
        logic              out_comb;   // 13
        logic [1:0]        set_src;    // 12:11  bit0 global, bit1 product term
        logic [1:0]        rst_src;    // 10:9   bit0 global, bit1 product term
        ce_src_e           ce_src;     // 8:7
        logic              clk_inv;    // 6
        logic [CSEL_W-1:0] clk_sel;    // 5:3
        logic              latch;      // 2
        logic              inv;        // 1
        logic              din_io;     // 0
    } mc_cfg_t;

    localparam int CFG_W = $bits(mc_cfg_t);

    function automatic logic src_hit(input logic [1:0] en, input logic g, input logic pt);
        return (en[0] & g) | (en[1] & pt);
    endfunction

    function automatic logic ce_ok(input ce_src_e s, input logic g, input logic pt);
        case (s)
            CE_ALWAYS: return 1'b1;
            CE_GLOBAL: return g;
            CE_PTERM:  return pt;
            default:   return g & pt;
        endcase
    endfunction

endpackage

// File: rtl/mc_cfg_reg.sv
module mc_cfg_reg
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output mc_cfg_t          cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= '0;
        else if (we)
            cfg_o <= mc_cfg_t'(wdata);
    end
endmodule

// File: rtl/mc_clk_ctl.sv
module mc_clk_ctl
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mc_cfg_t           cfg,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              gce,
    input  logic              pt_ce,
    output logic              open_o,
    output logic              fire_o
);
    logic [N_GCLK:0] src_vec;
    logic            lvl;
    logic            lvl_pol;
    logic            lvl_prev;
    logic            en;

    always_comb begin
        src_vec = {pt_clk, gclk};
        if (cfg.clk_sel <= CSEL_PT)
            lvl = src_vec[cfg.clk_sel];
        else
            lvl = 1'b0;
        lvl_pol = lvl ^ cfg.clk_inv;
        en      = ce_ok(cfg.ce_src, gce, pt_ce);
    end

    // Start high so a clock already high at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst)
            lvl_prev <= 1'b1;
        else
            lvl_prev <= lvl_pol;
    end

    assign open_o = lvl_pol & en;
    assign fire_o = lvl_pol & ~lvl_prev & en;
endmodule

// File: rtl/mc_store.sv
module mc_store (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic latch,
    input  logic open_i,
    input  logic fire_i,
    input  logic clr_i,
    input  logic set_i,
    output logic q_o
);
    logic q_state;
    logic load;

    assign load = latch ? open_i : fire_i;

    always_ff @(posedge clk) begin
        if (rst)
            q_state <= 1'b0;
        else if (clr_i)
            q_state <= 1'b0;
        else if (set_i)
            q_state <= 1'b1;
        else if (load)
            q_state <= d;
    end

    always_comb begin
        if (clr_i)
            q_o = 1'b0;
        else if (set_i)
            q_o = 1'b1;
        else if (latch && open_i)
            q_o = d;
        else
            q_o = q_state;
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              sop_in,
    input  logic              io_in,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              gce,
    input  logic              pt_ce,
    input  logic              g_rst,
    input  logic              pt_rst,
    input  logic              g_set,
    input  logic              pt_set,
    output logic              comb_out,
    output logic              reg_out
);
    mc_cfg_t cfg_q;
    logic    d_sel;
    logic    d_pol;
    logic    open_w;
    logic    fire_w;
    logic    clr_w;
    logic    set_w;
    logic    q_w;

    mc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_o (cfg_q)
    );

    mc_clk_ctl u_clk (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg_q),
        .gclk   (gclk),
        .pt_clk (pt_clk),
        .gce    (gce),
        .pt_ce  (pt_ce),
        .open_o (open_w),
        .fire_o (fire_w)
    );

    always_comb begin
        d_sel = cfg_q.din_io ? io_in : sop_in;
        d_pol = d_sel ^ cfg_q.inv;
        clr_w = src_hit(cfg_q.rst_src, g_rst, pt_rst);
        set_w = src_hit(cfg_q.set_src, g_set, pt_set);
    end

    mc_store u_store (
        .clk    (clk),
        .rst    (rst),
        .d      (d_pol),
        .latch  (cfg_q.latch),
        .open_i (open_w),
        .fire_i (fire_w),
        .clr_i  (clr_w),
        .set_i  (set_w),
        .q_o    (q_w)
    );

    assign comb_out = d_pol;
    assign reg_out  = cfg_q.out_comb ? d_pol : q_w;
endmodule

// File: rtl/mc_checker.sv
module mc_checker
    import mc_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input mc_cfg_t cfg,
    input logic    cfg_we,
    input logic    sop_in,
    input logic    io_in,
    input logic    gce,
    input logic    g_rst,
    input logic    pt_rst,
    input logic    g_set,
    input logic    pt_set,
    input logic    comb_out,
    input logic    reg_out
);
    logic clr_req;
    logic set_req;
    logic quiet;

    assign clr_req = (cfg.rst_src[0] & g_rst) | (cfg.rst_src[1] & pt_rst);
    assign set_req = (cfg.set_src[0] & g_set) | (cfg.set_src[1] & pt_set);
    assign quiet   = !cfg.latch && cfg.ce_src == CE_GLOBAL && !gce
                     && !clr_req && !set_req && !cfg.out_comb && !cfg_we;

    assert_cfg_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg == '0);

    assert_comb_path_R2: assert property (@(posedge clk) disable iff (rst)
        comb_out == ((cfg.din_io ? io_in : sop_in) ^ cfg.inv));

    assert_hold_no_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (quiet && $past(quiet)) |-> $stable(reg_out));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !cfg.out_comb) |-> !reg_out);

    assert_set_forces_R9: assert property (@(posedge clk) disable iff (rst)
        (set_req && !clr_req && !cfg.out_comb) |-> reg_out);

    assert_out_select_R10: assert property (@(posedge clk) disable iff (rst)
        cfg.out_comb |-> reg_out == comb_out);
endmodule

bind pld_macrocell mc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg_q),
    .cfg_we   (cfg_we),
    .sop_in   (sop_in),
    .io_in    (io_in),
    .gce      (gce),
    .g_rst    (g_rst),
    .pt_rst   (pt_rst),
    .g_set    (g_set),
    .pt_set   (pt_set),
    .comb_out (comb_out),
    .reg_out  (reg_out)
);

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb;
    import mc_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             sop_in = 1'b0, io_in = 1'b0;
    logic [N_GCLK-1:0] gclk = '0;
    logic             pt_clk = 1'b0, gce = 1'b0, pt_ce = 1'b0;
    logic             g_rst = 1'b0, pt_rst = 1'b0, g_set = 1'b0, pt_set = 1'b0;
    logic             comb_out, reg_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pld_macrocell u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sop_in(sop_in), .io_in(io_in), .gclk(gclk), .pt_clk(pt_clk),
        .gce(gce), .pt_ce(pt_ce), .g_rst(g_rst), .pt_rst(pt_rst),
        .g_set(g_set), .pt_set(pt_set), .comb_out(comb_out), .reg_out(reg_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Configuration encoding per R3..R10 bit positions.
    function automatic logic [CFG_W-1:0] mk(input logic dio, input logic inv,
        input logic lat, input int csel, input logic cinv, input int ce,
        input int rs, input int ss, input logic oc);
        logic [CFG_W-1:0] v;
        v = '0;
        v[0] = dio; v[1] = inv; v[2] = lat;
        v[5:3] = csel[2:0]; v[6] = cinv; v[8:7] = ce[1:0];
        v[10:9] = rs[1:0]; v[12:11] = ss[1:0]; v[13] = oc;
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        {sop_in, io_in, pt_clk, gce, pt_ce, g_rst, pt_rst, g_set, pt_set} = '0;
        gclk = '0; cfg_we = 1'b0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_g0();
        gclk[0] = 1'b1; step();
        gclk[0] = 1'b0; step();
    endtask

    task automatic t_reset_r1();
        sop_in = 1'b1; rst = 1'b1;
        step(); step();
        chk("R1 reg_out cleared", reg_out, 1'b0);
        chk("R1 comb passes sop", comb_out, 1'b1);
        rst = 1'b0; step();
        pulse_g0();
        chk("R1 default cfg captures on gclk0", reg_out, 1'b1);
    endtask

    task automatic t_comb_r2_r3();
        do_reset();
        sop_in = 1'b1; io_in = 1'b0; #1;
        chk("R2 comb sop=1", comb_out, 1'b1);
        sop_in = 1'b0; io_in = 1'b1; #1;
        chk("R3 io ignored when sop selected", comb_out, 1'b0);
        write_cfg(mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R3 io selected", comb_out, 1'b1);
        io_in = 1'b0; #1;
        chk("R3 io follows", comb_out, 1'b0);
        write_cfg(mk(1, 1, 0, 0, 0, 0, 0, 0, 0));
        chk("R2 inverted io=0", comb_out, 1'b1);
        io_in = 1'b1; #1;
        chk("R2 inverted io=1", comb_out, 1'b0);
        write_cfg(mk(1, 0, 0, 0, 0, 0, 0, 0, 0));
        sop_in = 1'b0; io_in = 1'b1;
        pulse_g0();
        chk("R3 io stored", reg_out, 1'b1);
    endtask

    task automatic t_reg_r4();
        do_reset();
        sop_in = 1'b1; gclk[0] = 1'b1; step();
        chk("R4 capture on rising", reg_out, 1'b1);
        sop_in = 1'b0; step();
        chk("R4 hold while high", reg_out, 1'b1);
        gclk[0] = 1'b0; step();
        chk("R4 hold while low", reg_out, 1'b1);
        gclk[0] = 1'b1; step();
        chk("R4 second rising", reg_out, 1'b0);
        gclk[0] = 1'b0; step();
    endtask

    task automatic t_clksel_r5();
        do_reset();
        write_cfg(mk(0, 0, 0, 2, 0, 0, 0, 0, 0));
        sop_in = 1'b1; pulse_g0();
        chk("R5 gclk0 ignored when sel=2", reg_out, 1'b0);
        gclk[2] = 1'b1; step();
        chk("R5 gclk2 captures", reg_out, 1'b1);
        gclk[2] = 1'b0; step();
        write_cfg(mk(0, 0, 0, 4, 0, 0, 0, 0, 0));
        sop_in = 1'b0; gclk = '1; step(); gclk = '0; step();
        chk("R5 globals ignored when sel=4", reg_out, 1'b1);
        pt_clk = 1'b1; step();
        chk("R5 pt_clk captures", reg_out, 1'b0);
        pt_clk = 1'b0; step();
        write_cfg(mk(0, 0, 0, 5, 0, 0, 0, 0, 0));
        sop_in = 1'b1; gclk = '1; pt_clk = 1'b1; step();
        gclk = '0; pt_clk = 1'b0; step();
        chk("R5 code 5 never clocks", reg_out, 1'b0);
    endtask

    task automatic t_inv_r6();
        do_reset();
        gclk[0] = 1'b1; step(); step();
        write_cfg(mk(0, 0, 0, 0, 1, 0, 0, 0, 0));
        sop_in = 1'b1; step();
        chk("R6 no capture while high", reg_out, 1'b0);
        gclk[0] = 1'b0; step();
        chk("R6 capture on falling", reg_out, 1'b1);
        sop_in = 1'b0; gclk[0] = 1'b1; step();
        chk("R6 rising ignored", reg_out, 1'b1);
    endtask

    task automatic t_ce_r7();
        do_reset();
        write_cfg(mk(0, 0, 0, 0, 0, 1, 0, 0, 0));
        sop_in = 1'b1; gce = 1'b0; pulse_g0();
        chk("R7 gce low blocks", reg_out, 1'b0);
        gce = 1'b1; pulse_g0();
        chk("R7 gce high captures", reg_out, 1'b1);
        write_cfg(mk(0, 0, 0, 0, 0, 2, 0, 0, 0));
        sop_in = 1'b0; gce = 1'b1; pt_ce = 1'b0; pulse_g0();
        chk("R7 pt_ce low blocks", reg_out, 1'b1);
        pt_ce = 1'b1; pulse_g0();
        chk("R7 pt_ce high captures", reg_out, 1'b0);
        write_cfg(mk(0, 0, 0, 0, 0, 3, 0, 0, 0));
        sop_in = 1'b1; gce = 1'b1; pt_ce = 1'b0; pulse_g0();
        chk("R7 both needs pt_ce", reg_out, 1'b0);
        gce = 1'b0; pt_ce = 1'b1; pulse_g0();
        chk("R7 both needs gce", reg_out, 1'b0);
        gce = 1'b1; pulse_g0();
        chk("R7 both active captures", reg_out, 1'b1);
    endtask

    task automatic t_latch_r8();
        do_reset();
        write_cfg(mk(0, 0, 1, 0, 0, 0, 0, 0, 0));
        gclk[0] = 1'b1; sop_in = 1'b1; #1;
        chk("R8 transparent 1", reg_out, 1'b1);
        sop_in = 1'b0; #1;
        chk("R8 transparent 0", reg_out, 1'b0);
        sop_in = 1'b1; step();
        gclk[0] = 1'b0; step();
        sop_in = 1'b0; #1;
        chk("R8 closed holds", reg_out, 1'b1);
        step();
        chk("R8 still holds", reg_out, 1'b1);
    endtask

    task automatic t_setrst_r9();
        do_reset();
        write_cfg(mk(0, 0, 0, 0, 0, 0, 1, 1, 0));
        g_set = 1'b1; #1;
        chk("R9 global set immediate", reg_out, 1'b1);
        step(); g_set = 1'b0; #1;
        chk("R9 set retained", reg_out, 1'b1);
        g_rst = 1'b1; g_set = 1'b1; #1;
        chk("R9 clear wins", reg_out, 1'b0);
        step(); g_rst = 1'b0; g_set = 1'b0; step();
        chk("R9 cleared retained", reg_out, 1'b0);
        write_cfg(mk(0, 0, 0, 0, 0, 0, 2, 2, 0));
        g_set = 1'b1; #1;
        chk("R9 global set unselected", reg_out, 1'b0);
        pt_set = 1'b1; #1;
        chk("R9 pt set", reg_out, 1'b1);
        step(); g_set = 1'b0; pt_set = 1'b0;
        g_rst = 1'b1; #1;
        chk("R9 global clear unselected", reg_out, 1'b1);
        pt_rst = 1'b1; #1;
        chk("R9 pt clear", reg_out, 1'b0);
        step(); g_rst = 1'b0; pt_rst = 1'b0; step();
    endtask

    task automatic t_outsel_r10();
        do_reset();
        sop_in = 1'b1; pulse_g0();
        write_cfg(mk(0, 0, 0, 0, 0, 0, 0, 0, 1));
        sop_in = 1'b0; #1;
        chk("R10 shows comb", reg_out, 1'b0);
        write_cfg(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R10 stored kept", reg_out, 1'b1);
    endtask

    task automatic t_cfg_r11();
        do_reset();
        sop_in = 1'b1;
        cfg_wdata = mk(0, 1, 0, 0, 0, 0, 0, 0, 0); cfg_we = 1'b1; #1;
        chk("R11 no effect before edge", comb_out, 1'b1);
        step(); cfg_we = 1'b0;
        chk("R11 effect after edge", comb_out, 1'b0);
    endtask

    initial begin
        t_reset_r1();
        t_comb_r2_r3();
        t_reg_r4();
        t_clksel_r5();
        t_inv_r6();
        t_ce_r7();
        t_latch_r8();
        t_setrst_r9();
        t_outsel_r10();
        t_cfg_r11();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule